// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block makes the bit clock for one serial channel. A 16-bit time constant, written as two bytes, sets how many source ticks make up each half of a square wave. The square wave toggles each time the down-counter reaches zero, so one full period is 2×(TC+2) source ticks. To reach a wanted rate, software picks TC = clock/(2·baud·divisor) − 2. For example, a 3.6864 MHz source gives TC = 10 for 9600 baud at ×16, and TC = 94 for 19200 baud at ×1.

Source ticks are single-cycle enables that run in the block's own clock domain. Each clock cycle on which the selected enable is high counts as one source tick. A clock-mode field sets a second division (1, 16, 32 or 64) of the square wave's rising edges. The result is a one-cycle baud tick for the character logic. Each zero count also gives a one-cycle pulse and sets a sticky status flag. If the zero-count source is unmasked, it also raises an interrupt request. Software clears both with an acknowledge write.

Top module: `baud_gen`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the block is in this state: bit_clk, baud_tick, zc_pulse and irq are 0, ext_status is 0x00, the time constant is 0, the clock mode is ×1, the interrupt mask is clear, and the generator is disabled.
- R2: The time constant is written as two bytes: the low byte at address 0 and the high byte at address 1. Bit 0 of the control register (address 3) enables the generator. A write that changes that bit from 0 to 1 restarts the generator: bit_clk goes to 0, and after that bit_clk toggles once every TC+2 selected source ticks.
- R3: A time-constant write while the generator runs does not shorten the half period in progress. The new value governs the half periods that start after the next zero count.
- R4: While bit 0 of the control register is 0, source ticks are not counted. bit_clk, zc_pulse and baud_tick hold steady.
- R5: Bit 1 of the control register selects the tick source: 0 selects src_tick[0] and 1 selects src_tick[1]. The other input has no effect.
- R6: zc_pulse is high for exactly one cycle for each zero count, and it is high in the same cycle in which bit_clk toggles.
- R7: Bits 7:6 of the mode register (address 2) select the divisor: 00 → 1, 01 → 16, 10 → 32, 11 → 64. baud_tick pulses for one cycle on every divisor-th rising edge of bit_clk, counted from the restart, and it is high in the same cycle in which bit_clk rises.
- R8: ext_status bit 1 is set by every zero count, whatever the mask, and stays set until a write to address 5 (acknowledge). If a zero count and an acknowledge fall in the same cycle, the flag stays set. All other ext_status bits read 0.
- R9: irq is set by a zero count only while bit 1 of the mask register (address 4) is 1. It is cleared by a write to address 5. If both fall in the same cycle, irq stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_tick | input | 2 | Source tick enables; bit 1 of the control register picks one |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| bit_clk | output | 1 | Square-wave bit clock |
| baud_tick | output | 1 | One-cycle pulse at the divided sampling rate |
| zc_pulse | output | 1 | One-cycle pulse per zero count |
| ext_status | output | 8 | Status byte; bit 1 is the sticky zero-count flag |
| irq | output | 1 | Zero-count interrupt request |

## Verification
Every internal state of this block reaches the ports within one half period. If the down-counter is wrong, the next bit_clk toggle and its zc_pulse land on the wrong cycle. If the prescaler is wrong, baud_tick appears on the wrong rising edge within at most 64 bit_clk periods. Pending and sticky flags show up in the cycle after the event or acknowledge that should change them. For this reason the bench compares every output on every clock cycle against a model built from the requirements. An offset of a single cycle is therefore found at the first toggle after it.

// File: rtl/brg_pkg.sv
// Package: brg_pkg
// Shared constants for the baud rate generator: register addresses, field
// positions and the clock-mode divisor decode. Assumes an 8-bit write bus.
package brg_pkg;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int TC_W     = 16;
    localparam int MAX_DIV  = 64;
    localparam int PRE_W    = $clog2(MAX_DIV);

    localparam logic [ADDR_W-1:0] A_TC_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_TC_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_MODE  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd3;
    localparam logic [ADDR_W-1:0] A_MASK  = 3'd4;
    localparam logic [ADDR_W-1:0] A_ACK   = 3'd5;

    typedef enum logic [1:0] {
        CM_X1  = 2'b00,
        CM_X16 = 2'b01,
        CM_X32 = 2'b10,
        CM_X64 = 2'b11
    } clk_mode_e;

    // Terminal value of the prescaler for a given clock mode (divisor - 1).
    function automatic logic [PRE_W-1:0] div_limit(input clk_mode_e m);
        case (m)
            CM_X16:  div_limit = PRE_W'(15);
            CM_X32:  div_limit = PRE_W'(31);
            CM_X64:  div_limit = PRE_W'(63);
            default: div_limit = '0;
        endcase
    endfunction
endpackage

// File: rtl/brg_regs.sv
// Module: brg_regs
// Holds the software-visible configuration: time constant, clock mode,
// enable, source select and zero-count mask. It decodes the acknowledge
// write and the restart event (enable written 0 -> 1). Assumes one write
// per cycle.
module brg_regs
    import brg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [TC_W-1:0]   tc,
    output clk_mode_e         mode,
    output logic              gen_en,
    output logic              src_sel,
    output logic              mask_zc,
    output logic              ack_wr,
    output logic              restart
);
    logic ctrl_wr;

    // Decode writes that act on the same cycle.
    always_comb begin
        ctrl_wr = wr_en && (wr_addr == A_CTRL);
        ack_wr  = wr_en && (wr_addr == A_ACK);
        restart = ctrl_wr && wr_data[0] && !gen_en;
    end

    // Configuration register file.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc      <= '0;
            mode    <= CM_X1;
            gen_en  <= 1'b0;
            src_sel <= 1'b0;
            mask_zc <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                A_TC_LO: tc[DATA_W-1:0]      <= wr_data;
                A_TC_HI: tc[TC_W-1:DATA_W]   <= wr_data;
                A_MODE:  mode                <= clk_mode_e'(wr_data[7:6]);
                A_CTRL: begin
                    gen_en  <= wr_data[0];
                    src_sel <= wr_data[1];
                end
                A_MASK:  mask_zc             <= wr_data[1];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/brg_counter.sv
// Module: brg_counter
// Down-counter producing the square-wave bit clock. A restart loads TC+1
// and clears the output. Each zero count reloads TC+1 from the time
// constant held at that moment and toggles the output, so each half period
// is TC+2 ticks. Assumes tick is low whenever restart is high.
module brg_counter
    import brg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            restart,
    input  logic [TC_W-1:0] tc,
    output logic            zc_evt,
    output logic            rise_evt,
    output logic            bit_clk,
    output logic            zc_pulse
);
    localparam int CNT_W = TC_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] reload;

    // Zero-count and rising-edge events for this cycle.
    always_comb begin
        reload   = {1'b0, tc} + CNT_W'(1);
        zc_evt   = tick && (cnt == '0);
        rise_evt = zc_evt && !bit_clk;
    end

    // Counter, output toggle and registered zero-count pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            bit_clk  <= 1'b0;
            zc_pulse <= 1'b0;
        end else begin
            zc_pulse <= zc_evt;
            if (restart) begin
                cnt     <= reload;
                bit_clk <= 1'b0;
            end else if (zc_evt) begin
                cnt     <= reload;
                bit_clk <= !bit_clk;
            end else if (tick) begin
                cnt     <= cnt - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/brg_rate_div.sv
// Module: brg_rate_div
// Divides the bit clock's rising edges by 1, 16, 32 or 64 according to
// the clock mode and emits a one-cycle baud tick. The prescaler clears on
// restart. Assumes the mode is changed only while the generator is idle.
module brg_rate_div
    import brg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rise_evt,
    input  logic      restart,
    input  clk_mode_e mode,
    output logic      baud_tick
);
    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] lim;
    logic             wrap;

    // Terminal detection for the selected divisor.
    always_comb begin
        lim  = div_limit(mode);
        wrap = (pre >= lim);
    end

    // Prescaler and registered baud tick.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pre       <= '0;
            baud_tick <= 1'b0;
        end else begin
            baud_tick <= rise_evt && wrap;
            if (rise_evt) begin
                pre <= wrap ? '0 : pre + PRE_W'(1);
            end
        end
    end
endmodule

// File: rtl/brg_irq.sv
// Module: brg_irq
// Zero-count reporting: a sticky status flag set by every zero count and a
// pending interrupt set only when unmasked. An acknowledge clears both; a
// simultaneous event wins over the clear.
module brg_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic zc_evt,
    input  logic mask_zc,
    input  logic ack_wr,
    output logic zc_seen,
    output logic irq_pend
);
    // Sticky status and pending request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zc_seen  <= 1'b0;
            irq_pend <= 1'b0;
        end else begin
            if (zc_evt)      zc_seen <= 1'b1;
            else if (ack_wr) zc_seen <= 1'b0;
            if (zc_evt && mask_zc) irq_pend <= 1'b1;
            else if (ack_wr)       irq_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/baud_gen.sv
// Module: baud_gen
// Top of the per-channel baud rate generator. It selects one of the source
// tick enables, runs the down-counter, divides its rising edges by the
// clock mode and reports zero counts. Single clock domain; the source
// ticks are enables, not clocks.
module baud_gen
    import brg_pkg::*;
#(
    parameter int NUM_SRC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic               bit_clk,
    output logic               baud_tick,
    output logic               zc_pulse,
    output logic [DATA_W-1:0]  ext_status,
    output logic               irq
);
    localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [TC_W-1:0] tc;
    clk_mode_e       mode;
    logic            gen_en;
    logic            src_sel;
    logic            mask_zc;
    logic            ack_wr;
    logic            restart;
    logic            tick;
    logic            zc_evt;
    logic            rise_evt;
    logic            zc_seen;

    brg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .tc      (tc),
        .mode    (mode),
        .gen_en  (gen_en),
        .src_sel (src_sel),
        .mask_zc (mask_zc),
        .ack_wr  (ack_wr),
        .restart (restart)
    );

    // Source selection: the width picks a plain gate or an indexed mux.
    generate
        if (NUM_SRC == 1) begin : g_one_src
            logic unused_sel;
            always_comb begin
                unused_sel = src_sel;
                tick       = gen_en && src_tick[0];
            end
        end else begin : g_mux_src
            always_comb tick = gen_en && src_tick[SEL_W'(src_sel)];
        end
    endgenerate

    brg_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .restart  (restart),
        .tc       (tc),
        .zc_evt   (zc_evt),
        .rise_evt (rise_evt),
        .bit_clk  (bit_clk),
        .zc_pulse (zc_pulse)
    );

    brg_rate_div u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_evt  (rise_evt),
        .restart   (restart),
        .mode      (mode),
        .baud_tick (baud_tick)
    );

    brg_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .zc_evt   (zc_evt),
        .mask_zc  (mask_zc),
        .ack_wr   (ack_wr),
        .zc_seen  (zc_seen),
        .irq_pend (irq)
    );

    // Status byte: only the zero-count flag is populated.
    always_comb ext_status = {{(DATA_W-2){1'b0}}, zc_seen, 1'b0};
endmodule

// File: rtl/brg_checker.sv
// Module: brg_checker
// Temporal properties of the baud rate generator, bound to baud_gen.
module brg_checker (
    input logic clk,
    input logic rst_n,
    input logic bit_clk,
    input logic zc_pulse,
    input logic baud_tick,
    input logic irq,
    input logic status_zc,
    input logic gen_en,
    input logic mask_zc,
    input logic ack_wr
);
    // R6: a zero-count pulse never lasts two cycles.
    p_zc_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        zc_pulse |=> !zc_pulse);

    // R2 / R6: bit_clk only rises together with a zero count.
    p_rise_on_zc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bit_clk) |-> zc_pulse);

    // R7: a baud tick coincides with a rising bit_clk.
    p_baud_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> $rose(bit_clk));

    // R4: two idle cycles in a row leave the outputs static.
    p_idle_static_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_en && !$past(gen_en)) |-> ($stable(bit_clk) && !zc_pulse && !baud_tick));

    // R9: irq only rises when the zero-count source was unmasked.
    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(mask_zc));

    // R8: the status flag holds without an acknowledge.
    p_status_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_zc && !ack_wr) |=> status_zc);

    // R8: an acknowledge with no new zero count clears the flag.
    p_status_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_wr |=> (zc_pulse || !status_zc));
endmodule

bind baud_gen brg_checker u_brg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_clk   (bit_clk),
    .zc_pulse  (zc_pulse),
    .baud_tick (baud_tick),
    .irq       (irq),
    .status_zc (ext_status[1]),
    .gen_en    (gen_en),
    .mask_zc   (mask_zc),
    .ack_wr    (ack_wr)
);

// File: tb/tb_baud_gen.sv
module tb_baud_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] src_tick = 2'b00;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic       bit_clk, baud_tick, zc_pulse, irq;
    logic [7:0] ext_status;

    int n_vec = 0;
    int n_bad = 0;
    string phase = "R1";

    typedef struct packed { logic b; logic z; logic bd; logic ir; logic st; } exp_t;
    exp_t sb[$];

    // Requirement model state
    int m_tc = 0, m_div = 1, m_rem = 0, m_rises = 0;
    bit m_en = 0, m_src = 0, m_mask = 0, m_bit = 0, m_stat = 0, m_pend = 0;

    baud_gen dut (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .bit_clk(bit_clk),
        .baud_tick(baud_tick), .zc_pulse(zc_pulse), .ext_status(ext_status), .irq(irq)
    );

    always #10 clk = ~clk;

    // Driver: drive one cycle of stimulus and push the expected outputs.
    task automatic step(input bit ta, input bit tb, input bit we, input int a, input int d);
        bit tick, zc, bd;
        @(negedge clk);
        src_tick = {tb, ta};
        wr_en = we; wr_addr = 3'(a); wr_data = 8'(d);
        tick = m_en && (m_src ? tb : ta);
        zc = 0; bd = 0;
        if (we && a == 3 && d[0] && !m_en) begin
            m_rem = m_tc + 2; m_bit = 0; m_rises = 0;
        end else if (tick) begin
            m_rem--;
            if (m_rem == 0) begin
                zc = 1;
                m_rem = m_tc + 2;
                if (!m_bit) begin
                    m_rises++;
                    if (m_rises % m_div == 0) bd = 1;
                end
                m_bit = !m_bit;
            end
        end
        if (zc) m_stat = 1; else if (we && a == 5) m_stat = 0;
        if (zc && m_mask) m_pend = 1; else if (we && a == 5) m_pend = 0;
        if (we) begin
            case (a)
                0: m_tc = (m_tc & 32'hFF00) | (d & 8'hFF);
                1: m_tc = (m_tc & 32'h00FF) | ((d & 8'hFF) << 8);
                2: m_div = (d[7:6] == 2'b00) ? 1 : (d[7:6] == 2'b01) ? 16 : (d[7:6] == 2'b10) ? 32 : 64;
                3: begin m_en = d[0]; m_src = d[1]; end
                4: m_mask = d[1];
                default: ;
            endcase
        end
        sb.push_back('{b: m_bit, z: zc, bd: bd, ir: m_pend, st: m_stat});
    endtask

    task automatic wr(input int a, input int d);
        step(1'b1, 1'b0, 1'b1, a, d);
    endtask

    // pat: 0 = only src 0 ticks every cycle, 1 = src 1 alternates, src 0 every cycle,
    //      2 = src 1 idle, src 0 every cycle
    task automatic run(input int n, input int pat);
        for (int i = 0; i < n; i++) begin
            case (pat)
                1: step(1'b1, i[0], 1'b0, 0, 0);
                2: step(1'b1, 1'b0, 1'b0, 0, 0);
                default: step(1'b1, 1'b0, 1'b0, 0, 0);
            endcase
        end
    endtask

    task automatic cmp(input string req, input string what, input logic got, input logic exp);
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] %s got %0b expected %0b at %0t", req, phase, what, got, exp, $time);
        end
    endtask

    // Monitor: sample away from the edge, pop and compare.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (rst_n && sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_vec++;
                cmp("R2", "bit_clk",   bit_clk,       e.b);
                cmp("R6", "zc_pulse",  zc_pulse,      e.z);
                cmp("R7", "baud_tick", baud_tick,     e.bd);
                cmp("R9", "irq",       irq,           e.ir);
                cmp("R8", "status[1]", ext_status[1], e.st);
                cmp("R8", "status[other]", |{ext_status[7:2], ext_status[0]}, 1'b0);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired got hang expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #5;
        // R1: reset state at the ports
        n_vec++;
        if (bit_clk !== 0 || baud_tick !== 0 || zc_pulse !== 0 || irq !== 0 || ext_status !== 8'h00) begin
            n_bad++;
            $display("FAIL R1 reset outputs got %b%b%b%b %h expected 0000 00",
                     bit_clk, baud_tick, zc_pulse, irq, ext_status);
        end
        @(negedge clk); rst_n = 1'b1;

        // R1: generator disabled out of reset, ticks do nothing
        phase = "R1 idle"; run(10, 0);

        // R2, R6, R7 (x1), R9: TC=3, mask on, source 0
        phase = "R2 tc3 x1";
        wr(0, 3); wr(1, 0); wr(2, 8'h00); wr(4, 8'h02); wr(3, 8'h01);
        run(60, 0);

        // R8, R9: acknowledge while running
        phase = "R8 R9 ack"; wr(5, 0); run(7, 0); wr(5, 0); run(13, 0);

        // R3: shorter TC mid-run applies at next reload
        phase = "R3 tc update"; wr(0, 1); run(40, 0);
        phase = "R3 tc grow";   wr(0, 9); run(50, 0);

        // R4: disabled holds outputs
        phase = "R4 disabled"; wr(3, 8'h00); run(30, 0); wr(5, 0); run(5, 0);

        // R2: high byte of TC (TC = 0x0100, half period 258)
        phase = "R2 tc high byte";
        wr(0, 0); wr(1, 1); wr(3, 8'h01); run(800, 0); wr(3, 8'h00);

        // R5: source 1 alternating, source 0 ignored
        phase = "R5 src1 alt";
        wr(1, 0); wr(0, 2); wr(3, 8'h03); run(120, 1);
        phase = "R5 src1 idle"; run(40, 2); wr(3, 8'h00);

        // R7: x16, x32, x64 with TC=0 (half period 2 ticks)
        phase = "R7 x16"; wr(0, 0); wr(2, 8'h40); wr(3, 8'h01); run(300, 0); wr(3, 8'h00);
        phase = "R7 x32"; wr(2, 8'h80); wr(3, 8'h01); run(400, 0); wr(3, 8'h00);
        phase = "R7 x64"; wr(2, 8'hC0); wr(3, 8'h01); run(700, 0); wr(3, 8'h00);

        // R9: masked source sets status but not irq
        phase = "R9 masked"; wr(5, 0); wr(4, 8'h00); wr(2, 8'h00); wr(0, 4);
        wr(3, 8'h01); run(40, 0); wr(5, 0); run(10, 0); wr(3, 8'h00);

        run(3, 0);
        @(negedge clk);
        @(negedge clk);
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL R2 scoreboard got %0d left expected 0", sb.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule